// File: doc/BRIEF.md
# Single-Wire Humidity and Temperature Sensor Reader

This block runs one complete read of a combined humidity and temperature sensor on an open-drain single-wire bus each time it is asked. A one-cycle start request makes it hold the bus low for a long wake-up interval and then let go. It follows the sensor's low/high acknowledge and times the high part of every data bit against a threshold taken from that acknowledge. It collects forty bits, tests the checksum byte and presents humidity and a signed temperature split into whole degrees and tenths.

The bus pin is modelled as an active-high pull-low enable (`line_oe_o`) and a raw input sample (`line_i`). The input passes through a two-flop synchroniser. All durations are counted in microsecond ticks from a clock divider. Every wait for a bus level has the same bounded timeout. A one-cycle `done_o` ends each request, and `status_o` holds the result code until the next request ends.

Top module: `hygro_wire_reader`

## Requirements
- R1: After reset `busy_o`, `done_o` and `line_oe_o` are 0, `status_o` is 0 and humidity, temperature whole part and tenths read 0.
- R2: A `start_i` seen while idle raises `busy_o` and `line_oe_o` on the next cycle. `line_oe_o` then stays high for at least START_US and at most START_US+2 microseconds before it is released.
- R3: A `start_i` while `busy_o` is high is ignored. The running read ends with one `done_o`, and the bus is not pulled low again afterwards.
- R4: Bits arrive most significant first. Byte 0 is the first eight bits and byte 4 the last. A bit whose high phase is longer than the threshold decodes as 1, otherwise as 0.
- R5: When byte 4 equals the 8-bit wrapping sum of bytes 0 to 3, `status_o` is 0 (success) and `humid_o` takes byte 0. Byte 1 enters the sum and affects no output.
- R6: On a checksum mismatch `status_o` is 2 and the three data outputs keep their previous values.
- R7: If any awaited bus level does not appear within TIMEOUT_US microseconds, the read aborts with `status_o` = 1. The bus is released and the data outputs keep their previous values.
- R8: When bit 7 of byte 3 is 0, `temp_int_o` is byte 2 and `temp_tenth_o` is the low four bits of byte 3.
- R9: When bit 7 of byte 3 is 1 and its low seven bits f are 0 to 9, the result depends on f. For f = 0, `temp_int_o` is the two's complement of byte 2 minus 1 and `temp_tenth_o` is 0. Otherwise `temp_int_o` is the two's complement of byte 2 and `temp_tenth_o` is 10 - f.
- R10: `done_o` is high for exactly one cycle per read, and `busy_o` is already low in that cycle.
- R11: A successful read finishes only after the bus returns high following the 40th bit. `done_o` never rises while the sensor holds the final low.
- R12: The threshold is half the measured length of the sensor's acknowledge-high phase. Doubling that phase turns a high phase that previously decoded as 1 into a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one read (single cycle) |
| line_i | input | 1 | Raw bus level, asynchronous |
| line_oe_o | output | 1 | 1 pulls the bus low, 0 releases it |
| busy_o | output | 1 | A read is in progress |
| done_o | output | 1 | One-cycle end-of-read strobe |
| status_o | output | 2 | 0 success, 1 timeout, 2 checksum error |
| humid_o | output | 8 | Relative humidity, whole percent |
| temp_int_o | output | 8 | Signed temperature, whole degrees |
| temp_tenth_o | output | 4 | Temperature tenths, 0 to 9 |

## Verification
A wrong threshold or a slipped bit counter shows up at the ports as soon as the read ends. The bytes are misaligned, so the checksum fails with status 2 or the reported values are wrong. A state machine that leaves a wait state early or late shows as `done_o` during the sensor's final low, or as a missing `done_o` that ends in a timeout one TIMEOUT_US later. Error paths that overwrite held data are caught on the cycle of `done_o` by comparing the data outputs with the previous read. The bench sweeps every tenths code in both signs and several bit patterns. It computes each expected value arithmetically.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_TMO = 2'd1,
    RES_SUM = 2'd2
  } hwr_result_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAKE,
    S_LETGO,
    S_ACK_LO,
    S_ACK_HI_W,
    S_ACK_HI,
    S_BIT_LO,
    S_BIT_HI,
    S_TAIL
  } hwr_state_e;

  typedef struct packed {
    logic [7:0] whole;
    logic [3:0] tenth;
  } hwr_temp_t;

  function automatic logic [7:0] sum4(input logic [31:0] d);
    return d[31:24] + d[23:16] + d[15:8] + d[7:0];
  endfunction

  // Sign lives in bit 7 of the fraction byte; negative values borrow from the
  // whole part when the complemented fraction reaches ten.
  function automatic hwr_temp_t conv_temp(input logic [7:0] ip, input logic [7:0] fp);
    hwr_temp_t  r;
    logic [7:0] t;
    r.whole = ip;
    r.tenth = fp[3:0];
    if (fp[7]) begin
      r.whole = 8'd0 - ip;
      t = 8'd10 - {1'b0, fp[6:0]};
      if (t == 8'd10) begin
        r.tenth = 4'd0;
        r.whole = r.whole - 8'd1;
      end else begin
        r.tenth = t[3:0];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/hwr_sync.sv
module hwr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      q_o    <= 1'b1;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/hwr_tick.sv
module hwr_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else if (div_q == DW'(DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DW'(DIV - 1));

      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o)
        else $error("tick repeated on consecutive cycles");
    end
  endgenerate
endmodule

// File: rtl/hwr_decode.sv
module hwr_decode
  import hwr_pkg::*;
(
  input  logic [39:0] frame_i,
  output logic        sum_ok_o,
  output logic [7:0]  humid_o,
  output hwr_temp_t   temp_o
);
  assign sum_ok_o = (sum4(frame_i[39:8]) == frame_i[7:0]);
  assign humid_o  = frame_i[39:32];
  assign temp_o   = conv_temp(frame_i[23:16], frame_i[15:8]);
endmodule

// File: rtl/hygro_wire_reader.sv
module hygro_wire_reader
  import hwr_pkg::*;
#(
  parameter int CLK_PER_US = 200,
  parameter int START_US   = 18500,
  parameter int TIMEOUT_US = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       line_i,
  output logic       line_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] status_o,
  output logic [7:0] humid_o,
  output logic [7:0] temp_int_o,
  output logic [3:0] temp_tenth_o
);
  localparam int NBITS   = 40;
  localparam int CNT_MAX = (START_US > TIMEOUT_US) ? START_US : TIMEOUT_US;
  localparam int CW      = $clog2(CNT_MAX + 2);
  localparam int BW      = $clog2(NBITS + 1);

  logic line_s, tick;
  hwr_sync u_sync (.clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s));
  hwr_tick #(.DIV(CLK_PER_US)) u_tick (.clk(clk), .rst_n(rst_n), .tick_o(tick));

  hwr_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, thresh_q;
  logic [39:0]    frame_q;
  logic [BW-1:0]  bit_cnt_q;

  // named events for the checks
  logic go_evt, abort_evt, end_evt, ack_meas_evt, bit_evt;
  logic wait_expired, bit_val;
  logic sum_ok;
  logic [7:0] dec_humid;
  hwr_temp_t  dec_temp;

  hwr_decode u_dec (.frame_i(frame_q), .sum_ok_o(sum_ok), .humid_o(dec_humid), .temp_o(dec_temp));

  assign wait_expired = (cnt_q >= CW'(TIMEOUT_US));
  assign bit_val      = (cnt_q > thresh_q);

  always_comb begin
    state_d      = state_q;
    go_evt       = 1'b0;
    abort_evt    = 1'b0;
    end_evt      = 1'b0;
    ack_meas_evt = 1'b0;
    bit_evt      = 1'b0;
    unique case (state_q)
      S_IDLE:     if (start_i) begin go_evt = 1'b1; state_d = S_WAKE; end
      S_WAKE:     if (cnt_q >= CW'(START_US)) state_d = S_LETGO;
      S_LETGO:    if (line_s) state_d = S_ACK_LO;   else if (wait_expired) abort_evt = 1'b1;
      S_ACK_LO:   if (!line_s) state_d = S_ACK_HI_W; else if (wait_expired) abort_evt = 1'b1;
      S_ACK_HI_W: if (line_s) state_d = S_ACK_HI;   else if (wait_expired) abort_evt = 1'b1;
      S_ACK_HI:   if (!line_s) begin ack_meas_evt = 1'b1; state_d = S_BIT_LO; end
                  else if (wait_expired) abort_evt = 1'b1;
      S_BIT_LO:   if (line_s) state_d = S_BIT_HI;   else if (wait_expired) abort_evt = 1'b1;
      S_BIT_HI:   if (!line_s) begin
                    bit_evt = 1'b1;
                    state_d = (bit_cnt_q == BW'(NBITS - 1)) ? S_TAIL : S_BIT_LO;
                  end else if (wait_expired) abort_evt = 1'b1;
      S_TAIL:     if (line_s) begin end_evt = 1'b1; state_d = S_IDLE; end
                  else if (wait_expired) abort_evt = 1'b1;
      default:    state_d = S_IDLE;
    endcase
    if (abort_evt) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      cnt_q        <= '0;
      thresh_q     <= '0;
      frame_q      <= '0;
      bit_cnt_q    <= '0;
      done_o       <= 1'b0;
      status_o     <= RES_OK;
      humid_o      <= '0;
      temp_int_o   <= '0;
      temp_tenth_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (tick && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (ack_meas_evt) thresh_q <= cnt_q >> 1;
      if (go_evt) bit_cnt_q <= '0;
      if (bit_evt) begin
        frame_q   <= {frame_q[38:0], bit_val};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      done_o <= end_evt | abort_evt;
      if (abort_evt) status_o <= RES_TMO;
      if (end_evt) begin
        status_o <= sum_ok ? RES_OK : RES_SUM;
        if (sum_ok) begin
          humid_o      <= dec_humid;
          temp_int_o   <= dec_temp.whole;
          temp_tenth_o <= dec_temp.tenth;
        end
      end
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign line_oe_o = (state_q == S_WAKE);

  p_oe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe_o |-> busy_o) else $error("bus pulled low while idle");
  p_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && line_oe_o)) else $error("start not taken");
  p_no_rewake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !line_oe_o) |=> !line_oe_o) else $error("bus pulled low again mid-read");
  p_bits_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= BW'(NBITS)) else $error("bit counter overran");
  p_hold_on_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o != RES_OK) |->
      ($stable(humid_o) && $stable(temp_int_o) && $stable(temp_tenth_o)))
    else $error("outputs changed on failed read");
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle");
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o) else $error("done while busy");
endmodule

// File: tb/hygro_wire_reader_tb.sv
module hygro_wire_reader_tb;
  localparam int CPU = 2;
  localparam int SUS = 20;
  localparam int TUS = 40;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, sens_low = 1'b0;
  logic line_oe_o, busy_o, done_o;
  logic [1:0] status_o;
  logic [7:0] humid_o, temp_int_o;
  logic [3:0] temp_tenth_o;
  wire line_i = !(line_oe_o || sens_low);

  always #2.5 clk = ~clk;

  hygro_wire_reader #(.CLK_PER_US(CPU), .START_US(SUS), .TIMEOUT_US(TUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
    .line_oe_o(line_oe_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .humid_o(humid_o), .temp_int_o(temp_int_o), .temp_tenth_o(temp_tenth_o));

  int n_chk = 0, n_bad = 0, cycles = 0;
  int rsp_hi = 16, fin_low = 10, oe_len = 0;
  logic clr_mon = 1'b0, dbl = 1'b0, early = 1'b0, done_prev = 1'b0;
  logic [1:0] g_st;
  logic [7:0] g_h, g_ti;
  logic [3:0] g_tf;
  logic g_seen;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<180000", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (clr_mon) begin dbl <= 1'b0; early <= 1'b0; end
    else begin
      if (done_o && done_prev) dbl <= 1'b1;
      if (done_o && sens_low) early <= 1'b1;
    end
    done_prev <= done_o;
  end

  task automatic us(input int n);
    repeat (n * CPU) @(negedge clk);
  endtask

  // md: 0 normal, 1 no answer, 2 stall low mid-frame, 3 no final release
  task automatic run(input logic [39:0] fr, input int md, input bit poke);
    clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), 1);
    oe_len = 0;
    while (line_oe_o) begin oe_len++; @(negedge clk); end
    if (md != 1) begin
      us(3); sens_low = 1'b1; us(16); sens_low = 1'b0; us(rsp_hi);
      for (int i = 39; i >= 0; i--) begin
        sens_low = 1'b1; us(10);
        if (md == 2 && i == 20) break;
        if (poke && i == 30) begin start_i = 1'b1; @(negedge clk); start_i = 1'b0; end
        sens_low = 1'b0; us(fr[i] ? 14 : 5);
      end
      if (md != 2) begin
        sens_low = 1'b1; us(fin_low);
        if (md != 3) sens_low = 1'b0;
      end
    end
    g_seen = 1'b0;
    for (int k = 0; k < 3000 && !g_seen; k++) begin
      if (done_o) begin
        g_seen = 1'b1; g_st = status_o; g_h = humid_o; g_ti = temp_int_o; g_tf = temp_tenth_o;
      end
      @(negedge clk);
    end
    sens_low = 1'b0;
    us(4);
    chk("R10 done seen", int'(g_seen), 1);
    chk("R10 done one cycle", int'(dbl), 0);
  endtask

  function automatic logic [39:0] mk(input logic [7:0] h, b1, t, f);
    logic [7:0] s = h + b1 + t + f;
    return {h, b1, t, f, s};
  endfunction

  task automatic good(input string req, input logic [7:0] h, b1, t, f);
    int ti, tf;
    run(mk(h, b1, t, f), 0, 1'b0);
    if (!f[7]) begin ti = t; tf = f[3:0]; end
    else if (f[6:0] == 0) begin ti = -int'(t) - 1; tf = 0; end
    else begin ti = -int'(t); tf = 10 - f[6:0]; end
    chk({req, " status"}, g_st, 0);
    chk({req, " humidity"}, g_h, h);
    chk({req, " whole"}, g_ti, ti & 255);
    chk({req, " tenths"}, g_tf, tf);
    chk("R11 no early done", int'(early), 0);
  endtask

  initial begin
    logic [7:0] ph, pti; logic [3:0] ptf;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 oe", int'(line_oe_o), 0);
    chk("R1 status", int'(status_o), 0);
    chk("R1 data", int'({humid_o, temp_int_o, temp_tenth_o}), 0);

    good("R5 R8", 8'd55, 8'd0, 8'd23, 8'd4);
    chk("R2 wake length lo", int'(oe_len >= SUS * CPU), 1);
    chk("R2 wake length hi", int'(oe_len <= (SUS + 2) * CPU), 1);
    good("R4 alt", 8'hA5, 8'h5A, 8'h3C, 8'h09);
    good("R5 byte1 ignored", 8'hA5, 8'hF0, 8'h3C, 8'h09);
    good("R4 ones", 8'hFF, 8'hFF, 8'h7F, 8'h00);
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 10; f++)
        good(s ? "R9 neg" : "R8 pos", 8'(40 + f), 8'(f * 3), 8'(f * 7), 8'((s << 7) | f));

    ph = g_h; pti = g_ti; ptf = g_tf;
    run({mk(8'd12, 8'd1, 8'd2, 8'd3)} ^ 40'h1, 0, 1'b0);
    chk("R6 status", g_st, 2);
    chk("R6 hold", int'({g_h, g_ti, g_tf}), int'({ph, pti, ptf}));
    for (int m = 1; m <= 3; m++) begin
      run(mk(8'd70, 8'd0, 8'd1, 8'd1), m, 1'b0);
      chk("R7 status", g_st, 1);
      chk("R7 hold", int'({g_h, g_ti, g_tf}), int'({ph, pti, ptf}));
      chk("R7 released", int'(line_oe_o), 0);
    end

    fin_low = 30;
    good("R11 long tail", 8'd33, 8'd2, 8'd18, 8'd5);
    fin_low = 10;

    run(mk(8'd61, 8'd0, 8'd21, 8'd7), 0, 1'b1);
    chk("R3 status", g_st, 0);
    chk("R3 humidity", g_h, 61);
    begin
      int seen = 0;
      repeat (120) begin @(negedge clk); if (line_oe_o || busy_o) seen++; end
      chk("R3 no second read", seen, 0);
    end

    rsp_hi = 32;
    run(mk(8'hFF, 8'hFF, 8'hFF, 8'hFF), 0, 1'b0);
    chk("R12 status", g_st, 0);
    chk("R12 humidity as zero", g_h, 0);
    chk("R12 whole as zero", g_ti, 0);
    rsp_hi = 16;

    finish_run();
  end
endmodule